// File: doc/BRIEF.md
# ADC Analog Watchdog Window Monitor

This block sits beside an analog-to-digital converter and inspects every sample result it produces. Each result arrives with a valid strobe, its channel number and the resolution it was converted at. The block first pads the result to a left-aligned 12-bit value: the bits that the active resolution does not produce are forced to zero. It then compares that value against a programmed high and low limit. When a guarded channel's sample falls outside the window, a sticky status flag is raised. An optional interrupt line follows the flag.

Software programs the limits, the guard mode and the interrupt enable through a simple register write port. It acknowledges an event by writing 1 to the status bit. The guard mode picks one of three choices: no channel, every channel, or a single channel named by a 5-bit select field.

Top module: `adc_window_guard`

## Requirements
- R1: The high and low limits come from bits [11:0] of a 16-bit write to address 0 (high) or address 1 (low). Bits [15:12] of the written word have no effect on the comparison.
- R2: On a cycle with `smp_valid` high and the sample's channel guarded, the flag is set if the padded sample is strictly greater than the high limit or strictly less than the low limit. A sample equal to either limit does not set it. With `smp_valid` low, nothing is set.
- R3: Before comparison, the sample is padded according to `smp_res`. Code 00 keeps bits [11:0]. Code 01 zeroes bits [1:0], code 10 zeroes bits [3:0], and code 11 zeroes bits [5:0].
- R4: The configuration write goes to address 2. Bit 0 is the watchdog enable, bit 1 selects single-channel mode, bits [6:2] hold the channel select and bit 7 is the interrupt enable. With bit 0 clear, no channel is guarded, whatever bit 1 holds.
- R5: With the enable set and single-channel mode clear, every channel number 0 to 31 is guarded.
- R6: With the enable and single-channel mode both set, only the channel equal to the select field is guarded.
- R7: A write to address 3 with bit 0 set clears the flag. A write there with bit 0 clear leaves the flag unchanged.
- R8: If a flag-setting sample and a clearing write occur in the same cycle, the flag ends up set.
- R9: Once set, the flag stays set through later in-window samples until it is cleared.
- R10: `wdg_irq` is high exactly when the flag and the interrupt enable are both 1.
- R11: After reset, the flag and interrupt are 0 and the high limit is 0xFFF. The low limit is 0x000, and the enable, mode, select and interrupt enable are all 0.
- R12: The flag changes on the clock edge that samples the valid strobe, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample result strobe |
| smp_data | input | 12 | Raw converter result |
| smp_chan | input | 5 | Channel of the sample |
| smp_res | input | 2 | Resolution code of the sample |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 high, 1 low, 2 config, 3 status) |
| reg_wdata | input | 16 | Register write data |
| wdg_flag | output | 1 | Sticky out-of-window flag |
| wdg_irq | output | 1 | Interrupt, flag gated by enable |

## Verification
Each window edge is approached from both sides, at one step beyond the limit and at the limit itself. This separates strict from inclusive comparison at both the high and the low side. Samples whose low bits alone would cross a limit are sent at every resolution code, which shows whether padding happens before the compare. The same out-of-window sample is then applied under each guard mode and on matching and non-matching channels. Limits written with their top nibble set expose any leak of those bits into the compare.

// File: rtl/adc_wdg_pkg.sv
package adc_wdg_pkg;

    typedef enum logic [1:0] {
        ADDR_HIGH   = 2'd0,
        ADDR_LOW    = 2'd1,
        ADDR_CONFIG = 2'd2,
        ADDR_STATUS = 2'd3
    } wdg_addr_e;

    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_SGL_BIT = 1;
    localparam int CFG_SEL_LSB = 2;
    localparam int STAT_FLAG_BIT = 0;

endpackage

// File: rtl/adc_wdg_quantize.sv
module adc_wdg_quantize #(
    parameter int DATA_W = 12,
    parameter int RES_W  = 2,
    parameter int STEP   = 2
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [RES_W-1:0]  res,
    output logic [DATA_W-1:0] padded
);
    localparam int NUM_RES = 1 << RES_W;

    logic [DATA_W-1:0] keep_mask [NUM_RES];

    for (genvar r = 0; r < NUM_RES; r++) begin : g_mask
        assign keep_mask[r] = {DATA_W{1'b1}} << (r * STEP);
    end

    assign padded = raw & keep_mask[res];
endmodule

// File: rtl/adc_wdg_chan_gate.sv
module adc_wdg_chan_gate #(
    parameter int CHAN_W = 5
) (
    input  logic              enable,
    input  logic              single,
    input  logic [CHAN_W-1:0] select,
    input  logic [CHAN_W-1:0] chan,
    output logic              guarded
);
    always_comb begin
        if (!enable)      guarded = 1'b0;
        else if (!single) guarded = 1'b1;
        else              guarded = (chan == select);
    end
endmodule

// File: rtl/adc_wdg_window.sv
module adc_wdg_window #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] upper,
    input  logic [DATA_W-1:0] lower,
    output logic              outside
);
    logic above;
    logic below;

    assign above   = value > upper;
    assign below   = value < lower;
    assign outside = above | below;
endmodule

// File: rtl/adc_window_guard.sv
module adc_window_guard #(
    parameter int DATA_W = 12,
    parameter int CHAN_W = 5,
    parameter int RES_W  = 2,
    parameter int REG_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [CHAN_W-1:0] smp_chan,
    input  logic [RES_W-1:0]  smp_res,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic              wdg_flag,
    output logic              wdg_irq
);
    import adc_wdg_pkg::*;

    localparam int CFG_IE_BIT = CFG_SEL_LSB + CHAN_W;

    typedef struct packed {
        logic [DATA_W-1:0] high;
        logic [DATA_W-1:0] low;
        logic              en;
        logic              sgl;
        logic [CHAN_W-1:0] sel;
        logic              ie;
        logic              flag;
    } wdg_state_t;

    wdg_state_t st_d, st_q;

    logic [DATA_W-1:0] padded;
    logic              guarded;
    logic              outside;
    logic              hit;
    logic              clr_req;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata;

    adc_wdg_quantize #(.DATA_W(DATA_W), .RES_W(RES_W), .STEP(2)) u_quant (
        .raw    (smp_data),
        .res    (smp_res),
        .padded (padded)
    );

    adc_wdg_chan_gate #(.CHAN_W(CHAN_W)) u_gate (
        .enable  (st_q.en),
        .single  (st_q.sgl),
        .select  (st_q.sel),
        .chan    (smp_chan),
        .guarded (guarded)
    );

    adc_wdg_window #(.DATA_W(DATA_W)) u_win (
        .value   (padded),
        .upper   (st_q.high),
        .lower   (st_q.low),
        .outside (outside)
    );

    assign hit     = smp_valid & guarded & outside;
    assign clr_req = reg_wr & (reg_addr == ADDR_W'(ADDR_STATUS))
                   & reg_wdata[STAT_FLAG_BIT];

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_W'(ADDR_HIGH): st_d.high = reg_wdata[DATA_W-1:0];
                ADDR_W'(ADDR_LOW):  st_d.low  = reg_wdata[DATA_W-1:0];
                ADDR_W'(ADDR_CONFIG): begin
                    st_d.en  = reg_wdata[CFG_EN_BIT];
                    st_d.sgl = reg_wdata[CFG_SGL_BIT];
                    st_d.sel = reg_wdata[CFG_SEL_LSB +: CHAN_W];
                    st_d.ie  = reg_wdata[CFG_IE_BIT];
                end
                default: ;
            endcase
        end
        if (clr_req) st_d.flag = 1'b0;
        if (hit)     st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.high <= '1;
            st_q.low  <= '0;
            st_q.en   <= 1'b0;
            st_q.sgl  <= 1'b0;
            st_q.sel  <= '0;
            st_q.ie   <= 1'b0;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wdg_flag = st_q.flag;
    assign wdg_irq  = st_q.flag & st_q.ie;
endmodule

// File: rtl/adc_wdg_checker.sv
module adc_wdg_checker (
    input logic clk,
    input logic rst_n,
    input logic smp_valid,
    input logic hit,
    input logic clr_req,
    input logic en_q,
    input logic wdg_flag,
    input logic wdg_irq
);
    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> wdg_flag); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_flag && !clr_req |=> wdg_flag); // R9
    AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req && !hit |=> !wdg_flag); // R7
    AST_QUIET_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !wdg_flag && !smp_valid |=> !wdg_flag); // R2
    AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !wdg_flag && !en_q |=> !wdg_flag); // R4
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_irq |-> wdg_flag); // R10
endmodule

bind adc_window_guard adc_wdg_checker u_wdg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .hit       (hit),
    .clr_req   (clr_req),
    .en_q      (st_q.en),
    .wdg_flag  (wdg_flag),
    .wdg_irq   (wdg_irq)
);

// File: tb/test_adc_window_guard.sv
`timescale 1ns/1ps
module test_adc_window_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic [4:0]  smp_chan = '0;
    logic [1:0]  smp_res = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        wdg_flag;
    logic        wdg_irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    adc_window_guard i_adc_window_guard (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_chan(smp_chan), .smp_res(smp_res), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .wdg_flag(wdg_flag), .wdg_irq(wdg_irq)
    );

    typedef struct packed {
        logic [15:0] high;
        logic [15:0] low;
        logic [7:0]  cfg;
        logic [4:0]  chan;
        logic [1:0]  res;
        logic [11:0] data;
        logic        exp_flag;
    } vec_t;

    localparam int NV = 24;
    // cfg: bit0 enable, bit1 single, [6:2] select, bit7 irq enable
    localparam vec_t VECS [NV] = '{
        '{16'h0800, 16'h0200, 8'h01, 5'd0,  2'd0, 12'h801, 1'b1}, // R2 above
        '{16'h0800, 16'h0200, 8'h01, 5'd0,  2'd0, 12'h800, 1'b0}, // R2 equal high
        '{16'h0800, 16'h0200, 8'h01, 5'd0,  2'd0, 12'h1FF, 1'b1}, // R2 below
        '{16'h0800, 16'h0200, 8'h01, 5'd0,  2'd0, 12'h200, 1'b0}, // R2 equal low
        '{16'hF400, 16'h0000, 8'h01, 5'd2,  2'd0, 12'h401, 1'b1}, // R1 high nibble ignored
        '{16'h0FFF, 16'hF100, 8'h01, 5'd2,  2'd0, 12'h0FF, 1'b1}, // R1 low below
        '{16'h0FFF, 16'hF100, 8'h01, 5'd2,  2'd0, 12'h800, 1'b0}, // R1 low nibble ignored
        '{16'h0800, 16'h0000, 8'h01, 5'd1,  2'd0, 12'h803, 1'b1}, // R3 12-bit keeps all
        '{16'h0800, 16'h0000, 8'h01, 5'd1,  2'd1, 12'h803, 1'b0}, // R3 10-bit pads
        '{16'h0800, 16'h0000, 8'h01, 5'd1,  2'd2, 12'h80F, 1'b0}, // R3 8-bit pads
        '{16'h0800, 16'h0000, 8'h01, 5'd1,  2'd3, 12'h83F, 1'b0}, // R3 6-bit pads
        '{16'h0800, 16'h0000, 8'h01, 5'd1,  2'd3, 12'h840, 1'b1}, // R3 6-bit over
        '{16'h0FFF, 16'h0204, 8'h01, 5'd1,  2'd1, 12'h207, 1'b0}, // R3 10-bit low ok
        '{16'h0FFF, 16'h0204, 8'h01, 5'd1,  2'd1, 12'h203, 1'b1}, // R3 10-bit low under
        '{16'h0800, 16'h0200, 8'h0E, 5'd3,  2'd0, 12'hFFF, 1'b0}, // R4 off, single set
        '{16'h0800, 16'h0200, 8'h00, 5'd3,  2'd0, 12'h000, 1'b0}, // R4 off, all
        '{16'h0800, 16'h0200, 8'h01, 5'd17, 2'd0, 12'hFFF, 1'b1}, // R5 ch17
        '{16'h0800, 16'h0200, 8'h01, 5'd31, 2'd0, 12'h000, 1'b1}, // R5 ch31
        '{16'h0800, 16'h0200, 8'h17, 5'd5,  2'd0, 12'hFFF, 1'b1}, // R6 match
        '{16'h0800, 16'h0200, 8'h17, 5'd4,  2'd0, 12'hFFF, 1'b0}, // R6 other
        '{16'h0800, 16'h0200, 8'h7F, 5'd31, 2'd0, 12'h100, 1'b1}, // R6 sel31
        '{16'h0800, 16'h0200, 8'h7F, 5'd0,  2'd0, 12'h100, 1'b0}, // R6 ch0 not sel
        '{16'h0800, 16'h0200, 8'h01, 5'd9,  2'd2, 12'h7FF, 1'b0}, // R3 inside
        '{16'h0800, 16'h0200, 8'h01, 5'd9,  2'd2, 12'h81F, 1'b1}  // R3 8-bit over
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic put(input logic [4:0] c, input logic [1:0] r, input logic [11:0] d);
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = c; smp_res = r; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 flag after reset", wdg_flag, 1'b0);
        chk("R11 irq after reset", wdg_irq, 1'b0);
        put(5'd0, 2'd0, 12'hFFF);
        chk("R11 enable off at reset", wdg_flag, 1'b0);
        wr(2'd2, 16'h0001);
        put(5'd0, 2'd0, 12'hFFF);
        chk("R11 reset high limit FFF", wdg_flag, 1'b0);
        put(5'd0, 2'd0, 12'h000);
        chk("R11 reset low limit 000", wdg_flag, 1'b0);

        for (int i = 0; i < NV; i++) begin
            wr(2'd0, VECS[i].high);
            wr(2'd1, VECS[i].low);
            wr(2'd2, {8'h00, VECS[i].cfg});
            wr(2'd3, 16'h0001);
            put(VECS[i].chan, VECS[i].res, VECS[i].data);
            chk($sformatf("vector %0d R1/R2/R3/R4/R5/R6", i), wdg_flag, VECS[i].exp_flag);
        end

        // R2: strobe low with out-of-window data
        wr(2'd0, 16'h0800); wr(2'd1, 16'h0200); wr(2'd2, 16'h0001); wr(2'd3, 16'h0001);
        @(negedge clk); smp_data = 12'hFFF; smp_valid = 1'b0;
        @(negedge clk);
        chk("R2 no strobe no set", wdg_flag, 1'b0);

        // R12: flag not before the edge, set after it
        smp_valid = 1'b1; smp_data = 12'hFFF; smp_chan = 5'd0; smp_res = 2'd0;
        #3;
        chk("R12 flag before edge", wdg_flag, 1'b0);
        @(negedge clk); smp_valid = 1'b0;
        chk("R12 flag after edge", wdg_flag, 1'b1);

        // R9: sticky through in-window samples
        put(5'd0, 2'd0, 12'h400);
        put(5'd0, 2'd0, 12'h500);
        chk("R9 sticky", wdg_flag, 1'b1);

        // R10: interrupt gating
        chk("R10 irq off with enable 0", wdg_irq, 1'b0);
        wr(2'd2, 16'h0081);
        chk("R10 irq on", wdg_irq, 1'b1);

        // R7: write 0 keeps, write 1 clears
        wr(2'd3, 16'h0000);
        chk("R7 write 0 keeps flag", wdg_flag, 1'b1);
        wr(2'd3, 16'h0001);
        chk("R7 write 1 clears flag", wdg_flag, 1'b0);
        chk("R10 irq follows clear", wdg_irq, 1'b0);

        // R8: set and clear in the same cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 16'h0001;
        smp_valid = 1'b1; smp_data = 12'h000; smp_chan = 5'd6; smp_res = 2'd0;
        @(negedge clk);
        reg_wr = 1'b0; smp_valid = 1'b0;
        chk("R8 set wins over clear", wdg_flag, 1'b1);
        chk("R10 irq with flag and enable", wdg_irq, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule